// File: doc/BRIEF.md
# MSI or legacy interrupt selector

This block sits between one device interrupt source and a PCI Express endpoint core. It delivers each interrupt by one of two methods. The first is a message-signaled interrupt request, sent over a request/acknowledge handshake. The second is a level-sensitive legacy INTx line. Only one method is in use at any time, and there is a single source, so no vector or source identity goes with a request.

The method is chosen by a local shadow of the MSI enable bit. The block watches the configuration-write notifications that the core reports. A write that updates the MSI message control field reaches the shadow only after a fixed, parameterised propagation delay. For that whole settle window the block raises a pending flag. During the window the previous method stays in force, so software or system logic can hold off interrupts until the flag drops.

When the method switches to MSI while the INTx line is asserted, the line is first deasserted and the MSI request follows one cycle later. The interrupt is therefore carried over and not lost.

Top module: `irq_mode_sel`

## Requirements
- R1: After reset, intx_o, msi_req_o and cfg_pending_o are 0 and msi_active_o is 0 (INTx method).
- R2: A snooped write with cfg_addr_i[11:2] equal to dword 0x050>>2 and cfg_be_i[2]=1 raises cfg_pending_o from the next cycle for exactly DELAY_CYCLES cycles. When the flag drops, msi_active_o takes cfg_data_i[16] of that write, and it keeps its old value while the flag is high.
- R3: A snooped write with cfg_be_i[2]=0, or to any other dword, has no effect: cfg_pending_o stays 0 and msi_active_o is unchanged.
- R4: A matching write while a settle is in flight restarts the full DELAY_CYCLES window and replaces the value to be applied; the last write wins.
- R5: While msi_active_o is 0 and no MSI request is outstanding, intx_o equals irq_i delayed by one cycle, and msi_req_o stays 0.
- R6: While msi_active_o is 1, a rising edge on irq_i raises msi_req_o one cycle later. msi_req_o stays high until msi_ack_i is sampled high, and it is low the cycle after the acknowledge.
- R7: Further rising edges on irq_i while a request is outstanding merge into it; no second request follows the acknowledge.
- R8: If the method becomes MSI while intx_o is high, intx_o falls one cycle after the switch and msi_req_o rises one cycle after that.
- R9: intx_o and msi_req_o are never high in the same cycle.
- R10: An interrupt raised inside a settle window is delivered with the method in force before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | Device interrupt level |
| cfg_wr_i | input | 1 | Configuration write notification strobe |
| cfg_addr_i | input | ADDR_W | Byte address of the configuration write |
| cfg_data_i | input | 32 | Write data dword |
| cfg_be_i | input | 4 | Byte enables of the write |
| msi_req_o | output | 1 | MSI request to the endpoint core |
| msi_ack_i | input | 1 | One-cycle acknowledge of the MSI request |
| intx_o | output | 1 | Legacy INTx assertion level |
| msi_active_o | output | 1 | Current delivery method, 1 = MSI |
| cfg_pending_o | output | 1 | A method update is still settling |

## Verification
Each result has a fixed latency, counted from the clock edge that samples the stimulus. intx_o and a new msi_req_o appear one edge after the irq_i change, and the drop of msi_req_o one edge after the acknowledge. cfg_pending_o rises one edge after the write and stays up for exactly DELAY_CYCLES edges. The INTx-to-MSI hand-over needs two further edges after msi_active_o changes. The bench drives inputs on the falling edge and samples outputs on the next falling edge, so each check lands exactly one registered stage after its stimulus. Settle windows are measured by counting falling edges with the flag high.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  localparam int unsigned MSI_CTRL_ADDR = 32'h050;
  localparam int unsigned MSI_EN_BIT    = 16;
  localparam int unsigned MSI_EN_BYTE   = MSI_EN_BIT / 8;

  typedef enum logic {
    MODE_INTX = 1'b0,
    MODE_MSI  = 1'b1
  } irq_mode_e;
endpackage

// File: rtl/irq_cfg_shadow.sv
module irq_cfg_shadow
  import irq_sel_pkg::*;
#(
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned DELAY_CYCLES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [31:0]       cfg_data_i,
  input  logic [3:0]        cfg_be_i,
  output irq_mode_e         mode_o,
  output logic              pending_o
);
  localparam int unsigned      CNT_W    = $clog2(DELAY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DELAY_CYCLES);
  localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(MSI_CTRL_ADDR);

  logic [CNT_W-1:0] cnt_q;
  irq_mode_e        stage_q, mode_q;
  logic             hit;

  // dword match plus byte lane that carries the enable bit
  assign hit = cfg_wr_i
             && (cfg_addr_i[ADDR_W-1:2] == CTRL_A[ADDR_W-1:2])
             && cfg_be_i[MSI_EN_BYTE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      stage_q <= MODE_INTX;
      mode_q  <= MODE_INTX;
    end else if (hit) begin
      cnt_q   <= CNT_LOAD;
      stage_q <= irq_mode_e'(cfg_data_i[MSI_EN_BIT]);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) mode_q <= stage_q;
    end
  end

  assign mode_o    = mode_q;
  assign pending_o = (cnt_q != '0);
endmodule

// File: rtl/irq_msi_req.sv
module irq_msi_req
  import irq_sel_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      irq_i,
  input  irq_mode_e mode_i,
  input  logic      intx_i,
  input  logic      ack_i,
  output logic      req_o,
  output logic      req_next_o
);
  logic irq_q, handoff_q, req_q, rise, set;

  assign rise = irq_i & ~irq_q;
  // handoff: intx was live when MSI took over, replay it as a request
  assign set  = (mode_i == MODE_MSI) & (rise | handoff_q);
  assign req_next_o = set | (req_q & ~ack_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q     <= 1'b0;
      handoff_q <= 1'b0;
      req_q     <= 1'b0;
    end else begin
      irq_q     <= irq_i;
      handoff_q <= (mode_i == MODE_MSI) & intx_i;
      req_q     <= req_next_o;
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/irq_intx_drv.sv
module irq_intx_drv
  import irq_sel_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      irq_i,
  input  irq_mode_e mode_i,
  input  logic      msi_busy_i,
  output logic      intx_o
);
  logic intx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) intx_q <= 1'b0;
    else         intx_q <= irq_i & (mode_i == MODE_INTX) & ~msi_busy_i;
  end

  assign intx_o = intx_q;
endmodule

// File: rtl/irq_mode_sel.sv
module irq_mode_sel
  import irq_sel_pkg::*;
#(
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned DELAY_CYCLES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_i,
  input  logic              cfg_wr_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [31:0]       cfg_data_i,
  input  logic [3:0]        cfg_be_i,
  output logic              msi_req_o,
  input  logic              msi_ack_i,
  output logic              intx_o,
  output logic              msi_active_o,
  output logic              cfg_pending_o
);
  irq_mode_e mode;
  logic      req_next, intx;

  irq_cfg_shadow #(
    .ADDR_W      (ADDR_W),
    .DELAY_CYCLES(DELAY_CYCLES)
  ) u_shadow (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_wr_i  (cfg_wr_i),
    .cfg_addr_i(cfg_addr_i),
    .cfg_data_i(cfg_data_i),
    .cfg_be_i  (cfg_be_i),
    .mode_o    (mode),
    .pending_o (cfg_pending_o)
  );

  irq_msi_req u_msi (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .irq_i     (irq_i),
    .mode_i    (mode),
    .intx_i    (intx),
    .ack_i     (msi_ack_i),
    .req_o     (msi_req_o),
    .req_next_o(req_next)
  );

  irq_intx_drv u_intx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .irq_i     (irq_i),
    .mode_i    (mode),
    .msi_busy_i(req_next),
    .intx_o    (intx)
  );

  assign intx_o       = intx;
  assign msi_active_o = (mode == MODE_MSI);
endmodule

// File: rtl/irq_mode_sel_chk.sv
module irq_mode_sel_chk #(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_i,
  input logic              cfg_wr_i,
  input logic [ADDR_W-1:0] cfg_addr_i,
  input logic [3:0]        cfg_be_i,
  input logic              msi_req_o,
  input logic              msi_ack_i,
  input logic              intx_o,
  input logic              msi_active_o,
  input logic              cfg_pending_o
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(32'h050);

  // R9
  excl_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(intx_o && msi_req_o));

  // R6
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msi_req_o && !msi_ack_i |=> msi_req_o);

  // R2
  settle_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i && cfg_be_i[2] && (cfg_addr_i[ADDR_W-1:2] == CTRL_A[ADDR_W-1:2])
    |=> cfg_pending_o);

  // R2
  mode_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_pending_o |-> $stable(msi_active_o));

  // R3
  lane_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i && !cfg_be_i[2] && !cfg_pending_o |=> !cfg_pending_o);

  // R5
  intx_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && !msi_req_o && !$past(msi_active_o) |-> intx_o == $past(irq_i));

  // R8
  intx_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msi_req_o) |-> !$past(intx_o));
endmodule

bind irq_mode_sel irq_mode_sel_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .irq_i        (irq_i),
  .cfg_wr_i     (cfg_wr_i),
  .cfg_addr_i   (cfg_addr_i),
  .cfg_be_i     (cfg_be_i),
  .msi_req_o    (msi_req_o),
  .msi_ack_i    (msi_ack_i),
  .intx_o       (intx_o),
  .msi_active_o (msi_active_o),
  .cfg_pending_o(cfg_pending_o)
);

// File: tb/irq_mode_sel_bench.sv
module irq_mode_sel_bench;
  localparam int AW = 12;
  localparam int D  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          irq = 1'b0, wr = 1'b0, ack = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   data = '0;
  logic [3:0]    be = '0;
  logic          req, intx, act, pend;
  int            errs = 0, checks = 0;

  always #4 clk = ~clk;

  irq_mode_sel #(.ADDR_W(AW), .DELAY_CYCLES(D)) u_irq_mode_sel (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .cfg_wr_i(wr),
    .cfg_addr_i(addr), .cfg_data_i(data), .cfg_be_i(be),
    .msi_req_o(req), .msi_ack_i(ack), .intx_o(intx),
    .msi_active_o(act), .cfg_pending_o(pend)
  );

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(input string r, input int a, input int e);
    checks++;
    if (a != e) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", r, a, e);
    end
  endtask

  task automatic cfg_write(input logic [AW-1:0] a, input logic en, input logic [3:0] b);
    addr = a; data = 32'(en) << 16; be = b; wr = 1'b1;
    tick();
    wr = 1'b0; be = '0; data = '0;
  endtask

  // counts cycles with pending high, returns at first cycle it is low
  task automatic settle(output int n);
    n = 0;
    while (pend && n < 100) begin n++; tick(); end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin : main
    int n;
    logic mode;
    repeat (3) tick();
    // R1
    chk("R1 intx", int'(intx), 0); chk("R1 req", int'(req), 0);
    chk("R1 pend", int'(pend), 0); chk("R1 mode", int'(act), 0);
    rst_n = 1'b1;
    tick();
    chk("R1 mode after release", int'(act), 0);

    // R5: sweep an irq pattern in INTx mode
    for (int i = 0; i < 16; i++) begin
      irq = 1'((16'hB4D3 >> i) & 1);
      tick();
      chk("R5 intx follows", int'(intx), int'(irq));
      chk("R5 no req", int'(req), 0);
    end
    irq = 1'b0; tick();

    // R3: every byte-enable pattern without lane 2, plus non-matching dwords
    mode = 1'b0;
    for (int b = 0; b < 16; b++) begin
      if (b[2]) continue;
      cfg_write(12'h050, 1'b1, 4'(b));
      chk("R3 lane ignored pend", int'(pend), 0);
      tick(); tick();
      chk("R3 lane ignored mode", int'(act), 0);
    end
    for (int k = 0; k < 4; k++) begin
      logic [AW-1:0] a;
      a = (k == 0) ? 12'h054 : (k == 1) ? 12'h04C : (k == 2) ? 12'h150 : 12'h850;
      cfg_write(a, 1'b1, 4'hF);
      chk("R3 addr ignored pend", int'(pend), 0);
      tick(); tick();
      chk("R3 addr ignored mode", int'(act), 0);
    end
    cfg_write(12'h052, 1'b1, 4'h4); // low address bits do not matter
    chk("R2 byte offset still matches", int'(pend), 1);
    settle(n);
    chk("R2 settle length", n, D);
    chk("R2 mode applied", int'(act), 1);
    mode = 1'b1;

    // R2: all byte-enable patterns with lane 2, toggling the bit each time
    for (int b = 0; b < 16; b++) begin
      if (!b[2]) continue;
      cfg_write(12'h050, ~mode, 4'(b));
      chk("R2 pend raised", int'(pend), 1);
      tick();
      chk("R2 old mode held", int'(act), int'(mode));
      settle(n);
      chk("R2 settle length", n, D - 1);
      mode = ~mode;
      chk("R2 new mode", int'(act), int'(mode));
    end
    if (mode) begin cfg_write(12'h050, 1'b0, 4'h4); settle(n); end

    // R4: restart, last write wins
    cfg_write(12'h050, 1'b1, 4'h4);
    repeat (3) tick();
    chk("R4 still pending", int'(pend), 1);
    cfg_write(12'h050, 1'b0, 4'h4);
    settle(n);
    chk("R4 restarted length", n, D);
    chk("R4 last wins", int'(act), 0);

    // R10 + R8: irq in settle window uses INTx, then hands over
    cfg_write(12'h050, 1'b1, 4'h4);
    irq = 1'b1;
    tick();
    chk("R10 old method intx", int'(intx), 1);
    chk("R10 no req yet", int'(req), 0);
    settle(n);
    chk("R8 mode now msi", int'(act), 1);
    chk("R8 intx still up", int'(intx), 1);
    chk("R8 no req at switch", int'(req), 0);
    tick();
    chk("R8 intx dropped", int'(intx), 0);
    chk("R8 req waits", int'(req), 0);
    tick();
    chk("R8 req raised", int'(req), 1);
    chk("R9 exclusive", int'(intx & req), 0);
    ack = 1'b1; tick(); ack = 1'b0;
    chk("R6 req dropped after ack", int'(req), 0);
    irq = 1'b0; repeat (2) tick();

    // R6 + R7: request, hold, merge, ack
    irq = 1'b1; tick();
    chk("R6 req on rise", int'(req), 1);
    repeat (4) begin tick(); chk("R6 req held", int'(req), 1); end
    irq = 1'b0; tick(); irq = 1'b1; tick();
    chk("R7 merged still one", int'(req), 1);
    ack = 1'b1; tick(); ack = 1'b0;
    chk("R6 cleared", int'(req), 0);
    repeat (4) begin tick(); chk("R7 no second req", int'(req), 0); end
    chk("R6 intx quiet in msi", int'(intx), 0);
    irq = 1'b0; tick();

    // R10: MSI in force during window back to INTx
    cfg_write(12'h050, 1'b0, 4'h4);
    irq = 1'b1; tick();
    chk("R10 old method msi", int'(req), 1);
    chk("R9 exclusive", int'(intx), 0);
    ack = 1'b1; tick(); ack = 1'b0;
    settle(n);
    chk("R10 mode back to intx", int'(act), 0);
    tick();
    chk("R5 intx after switch back", int'(intx), 1);
    chk("R5 no req", int'(req), 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule